// File: doc/BRIEF.md
# Signed Serial Shift-Add Multiplier

This block multiplies two signed two's-complement operands of WIDTH bits and returns the exact signed product in 2*WIDTH bits. It works through the multiplier one bit per clock, least significant bit first. In each step the multiplicand, sign-extended to the full product width and shifted left by the step index, is added to an accumulating product register when the current multiplier bit is 1. On the final step, where the multiplier bit carries negative weight, the shifted multiplicand is subtracted instead of added. Only one adder/subtractor and a few registers are needed, and a product takes WIDTH cycles.

A client raises `start` for one cycle with both operands present while the block is neither busy nor showing a result. `busy` then stays high for WIDTH cycles. `done` pulses for one cycle with the finished product on `product`. The product stays on the output until the next accepted start.

Top module: `seq_signed_mul`

## Requirements
- R1: For any pair of WIDTH-bit signed operands, `product` equals their exact signed product in 2*WIDTH-bit two's complement in the cycle `done` is high.
- R2: With WIDTH=4, operands 4'b1101 (-3) and 4'b0101 (+5) give `product` = 8'b11110001 (-15).
- R3: The most negative operand times itself, (-2^(WIDTH-1))^2, gives +2^(2*WIDTH-2) with no overflow.
- R4: A `start` sampled high while `busy` and `done` are both low is accepted. `busy` is high from the next cycle for exactly WIDTH cycles.
- R5: `done` is high for exactly one cycle, the cycle right after the last `busy` cycle. `busy` is low while `done` is high.
- R6: A `start` sampled while `busy` or `done` is high is ignored. The operands are not recaptured, and the running product's result is unchanged.
- R7: After `done`, `product` keeps its value until the next accepted `start`.
- R8: While reset is asserted and right after it, `busy` = 0, `done` = 0 and `product` = 0.
- R9: A multiplier of -2^(WIDTH-1), where only the sign bit is set, gives the negated multiplicand shifted left by WIDTH-1. This exercises the subtracting step alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a multiply with the operands present this cycle |
| op_a | input | WIDTH | Signed multiplicand |
| op_b | input | WIDTH | Signed multiplier |
| busy | output | 1 | High while the bit-serial steps run |
| done | output | 1 | One-cycle pulse with a valid product |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
A 4-bit instance is driven through all 256 operand pairs. This separates a design that handles the sign bit of either operand wrongly from a correct one, since any fault in sign extension or in the subtracting last step shows up there. The 16-bit instance gets directed extremes: zero, -1 times -1, the most negative value squared, and max times min. It also gets seeded random pairs, which catch carries across the whole 32-bit accumulator. Start pulses injected in the middle of a run and during `done` show whether operands are wrongly recaptured. Cycle counts of `busy` and `done`, and product values sampled after `done`, check the handshake timing and the hold behaviour.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    load_en   = 1'b0;
    step_en   = 1'b0;
    last_step = (cnt_q == LAST_IDX);
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_en = 1'b1;
        if (last_step) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = (state_q == ST_DONE);

  // R4: the step counter never leaves the operand range while running
  assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST_IDX));
  // R5: done is a single-cycle pulse and excludes busy
  assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6: a start during a run neither restarts nor ends it early
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> busy);
endmodule

// File: rtl/seq_mul_shifter.sv
module seq_mul_shifter #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] pp,
  output logic               cur_bit
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    mcand_q, mcand_d;
  logic [WIDTH-1:0] mplier_q, mplier_d;

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    if (load_en) begin
      mcand_d  = {{WIDTH{op_a[WIDTH-1]}}, op_a};
      mplier_d = op_b;
    end else if (step_en) begin
      mcand_d  = {mcand_q[PW-2:0], 1'b0};
      mplier_d = {1'b0, mplier_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
    end else begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
    end
  end

  assign pp      = mcand_q;
  assign cur_bit = mplier_q[0];

  // R6: operands stay put unless loaded or stepped
  assert_operands_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> ($stable(mcand_q) && $stable(mplier_q)));
endmodule

// File: rtl/seq_mul_accum.sv
module seq_mul_accum #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  logic               last_step,
  input  logic               cur_bit,
  input  logic [2*WIDTH-1:0] pp,
  output logic [2*WIDTH-1:0] acc
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum   = last_step ? (acc_q - pp) : (acc_q + pp);
    acc_d = acc_q;
    if (load_en) begin
      acc_d = '0;
    end else if (step_en && cur_bit) begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R7: product holds whenever no load or step happens
  assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(acc_q));
  // R1: a step with a zero multiplier bit leaves the sum alone
  assert_zero_bit_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cur_bit && !load_en) |=> $stable(acc_q));
endmodule

// File: rtl/seq_signed_mul.sv
module seq_signed_mul #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       load_en, step_en, last_step, cur_bit;
  logic [2*WIDTH-1:0] pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  seq_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .start(start),
    .load_en(load_en), .step_en(step_en), .last_step(last_step),
    .busy(busy), .done(done)
  );

  seq_mul_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n_i), .load_en(load_en), .step_en(step_en),
    .op_a(op_a), .op_b(op_b), .pp(pp), .cur_bit(cur_bit)
  );

  seq_mul_accum #(.WIDTH(WIDTH)) u_acc (
    .clk(clk), .rst_n(rst_n_i), .load_en(load_en), .step_en(step_en),
    .last_step(last_step), .cur_bit(cur_bit), .pp(pp), .acc(product)
  );

  // R8: nothing is reported while reset is held
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n_i |-> (!busy && !done && product == '0));
endmodule

// File: tb/tb_seq_signed_mul.sv
module tb_seq_signed_mul;
  localparam int  W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start4 = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [3:0]   a4 = '0, b4 = '0;
  logic busy, done, busy4, done4;
  logic [2*W-1:0] product;
  logic [7:0]     product4;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_signed_mul #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product));

  seq_signed_mul #(.WIDTH(4)) dut_w4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .op_a(a4), .op_b(b4),
    .busy(busy4), .done(done4), .product(product4));

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return (2*W)'(sa * sb);
  endfunction

  function automatic logic [7:0] ref_mul4(input logic [3:0] a, input logic [3:0] b);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    return 8'(sa * sb);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // poke: 0 none, 1 start mid-run, 2 start during done
  task automatic run16(input logic [W-1:0] a, input logic [W-1:0] b, input int poke,
                       input string req);
    logic [2*W-1:0] exp;
    int busy_cycles;
    exp = ref_mul(a, b);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cycles = 0;
    for (int i = 0; i < W; i++) begin
      if (busy) busy_cycles++;
      if (poke == 1 && i == 3) begin
        op_a = ~a; op_b = b ^ 16'h5A5A; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (i < W - 1) @(negedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    check(busy_cycles == W, "R4", "busy length", 64'(busy_cycles), 64'(W));
    check(done && !busy, "R5", "done after run", {62'd0, done, busy}, 64'b10);
    check(product == exp, req, "product", 64'(product), 64'(exp));
    if (poke == 2) begin
      op_a = ~a; op_b = ~b; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    check(!done, "R5", "done one cycle", 64'(done), 64'd0);
    check(!busy, "R6", "start during done ignored", 64'(busy), 64'd0);
    @(negedge clk);
    check(product == exp, "R7", "product held", 64'(product), 64'(exp));
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input string req);
    logic [7:0] exp;
    exp = ref_mul4(a, b);
    @(negedge clk);
    a4 = a; b4 = b; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    repeat (4) @(negedge clk);
    check(done4 && product4 == exp, req, "w4 product", {55'd0, done4, product4}, {55'd0, 1'b1, exp});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] ra, rb;
    int unused_seed;
    unused_seed = $urandom(32'd20021);
    repeat (3) @(negedge clk);
    check(!busy && !done && product == '0, "R8", "during reset",
          {31'd0, busy, done, product}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && product == '0, "R8", "after reset",
          {31'd0, busy, done, product}, 64'd0);

    // R2: the worked 4-bit example
    run4(4'b1101, 4'b0101, "R2");
    check(product4 == 8'b1111_0001, "R2", "-3*5", 64'(product4), 64'hF1);
    // R1: every 4-bit operand pair
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run4(4'(x), 4'(y), "R1");

    // directed 16-bit corners
    run16(16'h8000, 16'h8000, 0, "R3");
    check(product == 32'h4000_0000, "R3", "min squared", 64'(product), 64'h4000_0000);
    run16(16'h1234, 16'h8000, 0, "R9");
    run16(16'hFFFF, 16'h8000, 0, "R9");
    run16(16'h0000, 16'h7FFF, 0, "R1");
    run16(16'hFFFF, 16'hFFFF, 0, "R1");
    run16(16'h7FFF, 16'h8000, 0, "R1");
    run16(16'h7FFF, 16'h7FFF, 0, "R1");
    run16(16'hFFFD, 16'h0005, 0, "R1");
    // R6: start pulses during busy and during done
    run16(16'h0ABC, 16'hF00D, 1, "R6");
    run16(16'hC001, 16'h0707, 2, "R6");

    // R1: seeded random operands
    for (int k = 0; k < 60; k++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      run16(ra, rb, (k % 7 == 0) ? 1 : 0, "R1");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule